// File: doc/BRIEF.md
# Berlekamp-Massey Error Locator Solver

This block solves the key equation of a Reed-Solomon (255,239) decoder over GF(2^8) with correction capability t = 8. It takes the 2t = 16 syndromes as a stream, one per accepted cycle and in rising index order. It runs one Berlekamp-Massey iteration on each syndrome as it arrives. The block can therefore sit in the same pipeline stage as the syndrome generator and adds no wait for a complete syndrome array. After the sixteenth syndrome, the block holds the error locator polynomial and its degree, and it pulses `done` for one cycle. It also presents the first t coefficients of the error evaluator polynomial for a later magnitude stage.

The control is a three-state machine:
- `ST_IDLE` waits for `start`.
- `ST_ACCUM` runs one iteration per valid syndrome.
- `ST_REPORT` lasts exactly one cycle and drives `done`.

The transitions are:
- IDLE to ACCUM on `start`.
- ACCUM to REPORT on the sixteenth accepted syndrome.
- REPORT to IDLE unconditionally.
- Any state to ACCUM on `start`, which also reinitialises all state.

Each iteration forms the discrepancy from the running locator and the syndrome window. When the discrepancy is zero, the locator and degree carry over unchanged. Otherwise a scaled and shifted copy of the stored correction polynomial is added. When twice the current degree does not exceed the step index, the degree becomes step + 1 - degree, and the stored polynomial and divisor are replaced.

Top module: `rs_kes_bm`

## Requirements
- R1: After reset, `done` is 0, `loc_deg` is 0 and `loc_coef` equals the constant polynomial 1 (byte 0 = 0x01, all other bytes 0).
- R2: A cycle with `start` high reinitialises the block so that in the next cycle the locator is 1 and the degree is 0. A `syn_valid` in that same cycle is not consumed.
- R3: While accumulating, each cycle with `syn_valid` high and `start` low consumes one syndrome, taken in order S1, S2, ..., S16. Cycles without `syn_valid` leave the iteration paused, so a gapped stream gives the same result as a dense one.
- R4: When the syndromes come from v <= 8 errors at distinct positions p with nonzero values Y (S_j = XOR of Y * alpha^(p*j)), `loc_deg` equals v and `loc_coef` equals the product of (1 + alpha^p x). Coefficient i is packed at bits [8i+7:8i].
- R5: `done` is high for exactly one cycle: the cycle right after the edge that accepts the sixteenth syndrome. It is low at all other times.
- R6: Outside accumulation (and without `start`), `syn_valid` has no effect: the locator, degree and evaluator outputs stay unchanged and `done` stays low.
- R7: After `done`, `eval_coef` byte k (bits [8k+7:8k], k = 0..7) equals XOR over i = 0..k of Lambda_i * S_(k+1-i).
- R8: Coefficient 0 of the locator is always 0x01 and the degree never exceeds 16. In the boundary case where only S16 = d is nonzero, every earlier step carries over unchanged and the result is degree 16 with locator 1 + d*x^16.
- R9: Field arithmetic uses the polynomial x^8+x^4+x^3+x^2+1 with primitive element alpha = 0x02. Bit i of a symbol is the coefficient of x^i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new codeword, clearing all iteration state |
| syn_valid | input | 1 | `syn_in` carries the next syndrome |
| syn_in | input | 8 | Syndrome symbol, S1 first |
| done | output | 1 | One-cycle pulse after the last syndrome |
| loc_deg | output | 5 | Degree of the error locator |
| loc_coef | output | 136 | Locator coefficients 0..16, byte i = coefficient i |
| eval_coef | output | 64 | Evaluator coefficients 0..7, byte k = coefficient k |

## Verification
The assertions assume three things about the inputs. First, `syn_in` matters only when `syn_valid` is high. Second, a codeword's syndromes follow a `start`. Third, a fresh `start` may arrive at any point, even in the middle of a stream or alongside `syn_valid`. The stimulus keeps within that contract. It forms the syndromes arithmetically from zero to eight errors at distinct positions with nonzero values, so the expected locator is the product of the known root factors. It presents each set densely, with idle gaps, or after an aborted partial stream whose restart collides with a stray valid. One hand-built pattern with only the last syndrome nonzero drives the degree to its upper bound.

// File: rtl/rs_kes_pkg.sv
package rs_kes_pkg;

    localparam int SYM_W = 8;
    localparam logic [SYM_W-1:0] POLY_LOW = 8'h1D; // x^8+x^4+x^3+x^2+1 without x^8

    typedef logic [SYM_W-1:0] gf_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_REPORT = 2'd2
    } kes_state_e;

    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t acc;
        gf_t run;
        acc = '0;
        run = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ run;
            run = run[SYM_W-1] ? ((run << 1) ^ POLY_LOW) : (run << 1);
        end
        return acc;
    endfunction

    // a^254 = a^-1 for nonzero a; squares a^2..a^128 multiplied together
    function automatic gf_t gf_inv(input gf_t a);
        gf_t sq;
        gf_t res;
        sq  = a;
        res = 8'h01;
        for (int i = 1; i < SYM_W; i++) begin
            sq  = gf_mul(sq, sq);
            res = gf_mul(res, sq);
        end
        return res;
    endfunction

endpackage

// File: rtl/rs_kes_disc.sv
module rs_kes_disc
    import rs_kes_pkg::*;
#(
    parameter int NCOEF = 17
) (
    input  logic [NCOEF*SYM_W-1:0] loc,
    input  logic [NCOEF*SYM_W-1:0] win,
    output gf_t                    disc
);

    logic [NCOEF*SYM_W-1:0] prod;

    for (genvar i = 0; i < NCOEF; i++) begin : g_term
        assign prod[i*SYM_W +: SYM_W] = gf_mul(loc[i*SYM_W +: SYM_W], win[i*SYM_W +: SYM_W]);
    end

    always_comb begin
        disc = '0;
        for (int i = 0; i < NCOEF; i++) begin
            disc = disc ^ prod[i*SYM_W +: SYM_W];
        end
    end

endmodule

// File: rtl/rs_kes_upd.sv
module rs_kes_upd
    import rs_kes_pkg::*;
#(
    parameter int NCOEF = 17
) (
    input  logic [NCOEF*SYM_W-1:0] loc,
    input  logic [NCOEF*SYM_W-1:0] bsh,
    input  gf_t                    disc,
    input  gf_t                    bprev,
    output logic [NCOEF*SYM_W-1:0] loc_new
);

    gf_t scale;

    assign scale = gf_mul(disc, gf_inv(bprev));

    for (genvar i = 0; i < NCOEF; i++) begin : g_coef
        assign loc_new[i*SYM_W +: SYM_W] =
            loc[i*SYM_W +: SYM_W] ^ gf_mul(scale, bsh[i*SYM_W +: SYM_W]);
    end

endmodule

// File: rtl/rs_kes_eval.sv
module rs_kes_eval
    import rs_kes_pkg::*;
#(
    parameter int CORR = 8
) (
    input  logic [CORR*SYM_W-1:0] loc_lo,
    input  logic [CORR*SYM_W-1:0] syn_lo,   // entry CORR-m holds S_m, m = 1..CORR
    output logic [CORR*SYM_W-1:0] omega
);

    for (genvar k = 0; k < CORR; k++) begin : g_omega
        always_comb begin
            omega[k*SYM_W +: SYM_W] = '0;
            for (int i = 0; i <= k; i++) begin
                omega[k*SYM_W +: SYM_W] = omega[k*SYM_W +: SYM_W]
                    ^ gf_mul(loc_lo[i*SYM_W +: SYM_W], syn_lo[(CORR-(k+1-i))*SYM_W +: SYM_W]);
            end
        end
    end

endmodule

// File: rtl/rs_kes_bm.sv
module rs_kes_bm
    import rs_kes_pkg::*;
#(
    parameter int CORR = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             syn_valid,
    input  logic [7:0]                       syn_in,
    output logic                             done,
    output logic [$clog2(2*CORR+1)-1:0]      loc_deg,
    output logic [(2*CORR+1)*8-1:0]          loc_coef,
    output logic [CORR*8-1:0]                eval_coef
);

    localparam int NSYN      = 2 * CORR;
    localparam int NCOEF     = NSYN + 1;
    localparam int CNT_W     = $clog2(NSYN);
    localparam int DEG_W     = $clog2(NSYN + 1);
    localparam int LOC_BITS  = NCOEF * SYM_W;
    localparam int HIST_BITS = NSYN * SYM_W;
    localparam int LOW_BITS  = CORR * SYM_W;

    kes_state_e            state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [DEG_W-1:0]      len_q, len_d;
    logic [LOC_BITS-1:0]   loc_q, loc_d, bsh_q, bsh_d, loc_upd;
    logic [HIST_BITS-1:0]  hist_q;
    logic [LOC_BITS-1:0]   window;
    gf_t                   bprev_q, bprev_d, disc;
    logic                  take, last, grow;

    assign window = {hist_q, syn_in};

    rs_kes_disc #(.NCOEF(NCOEF)) u_disc (
        .loc  (loc_q),
        .win  (window),
        .disc (disc)
    );

    rs_kes_upd #(.NCOEF(NCOEF)) u_upd (
        .loc     (loc_q),
        .bsh     (bsh_q),
        .disc    (disc),
        .bprev   (bprev_q),
        .loc_new (loc_upd)
    );

    rs_kes_eval #(.CORR(CORR)) u_eval (
        .loc_lo (loc_q[LOW_BITS-1:0]),
        .syn_lo (hist_q[HIST_BITS-1 -: LOW_BITS]),
        .omega  (eval_coef)
    );

    always_comb begin
        take = (state_q == ST_ACCUM) && syn_valid && !start;
        last = take && (cnt_q == CNT_W'(NSYN - 1));
        grow = (disc != '0) && ({len_q, 1'b0} <= (DEG_W + 1)'(cnt_q));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ACCUM;
            ST_ACCUM:  if (start) state_d = ST_ACCUM;
                       else if (last) state_d = ST_REPORT;
            ST_REPORT: state_d = start ? ST_ACCUM : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // iteration datapath
    always_comb begin
        loc_d   = loc_q;
        bsh_d   = bsh_q;
        len_d   = len_q;
        bprev_d = bprev_q;
        if (start) begin
            loc_d   = LOC_BITS'(1);
            bsh_d   = LOC_BITS'(1) << SYM_W;
            len_d   = '0;
            bprev_d = 8'h01;
        end else if (take) begin
            if (disc == '0) begin
                bsh_d = bsh_q << SYM_W;
            end else if (grow) begin
                loc_d   = loc_upd;
                bsh_d   = loc_q << SYM_W;
                len_d   = DEG_W'(cnt_q) + DEG_W'(1) - len_q;
                bprev_d = disc;
            end else begin
                loc_d = loc_upd;
                bsh_d = bsh_q << SYM_W;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_q   <= LOC_BITS'(1);
            bsh_q   <= LOC_BITS'(1) << SYM_W;
            len_q   <= '0;
            bprev_q <= 8'h01;
            hist_q  <= '0;
            cnt_q   <= '0;
        end else begin
            loc_q   <= loc_d;
            bsh_q   <= bsh_d;
            len_q   <= len_d;
            bprev_q <= bprev_d;
            if (start) begin
                hist_q <= '0;
                cnt_q  <= '0;
            end else if (take) begin
                hist_q <= {hist_q[HIST_BITS-SYM_W-1:0], syn_in};
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    // output decode
    always_comb begin
        done     = (state_q == ST_REPORT);
        loc_deg  = len_q;
        loc_coef = loc_q;
    end

endmodule

// File: rtl/rs_kes_bm_chk.sv
module rs_kes_bm_chk
    import rs_kes_pkg::*;
#(
    parameter int CORR = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        syn_valid,
    input kes_state_e                  state,
    input logic                        done,
    input logic [$clog2(2*CORR+1)-1:0] loc_deg,
    input logic [(2*CORR+1)*8-1:0]     loc_coef
);

    localparam int DEG_W    = $clog2(2*CORR+1);
    localparam int LOC_BITS = (2*CORR+1)*8;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_ACCUM && syn_valid && !start));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_ACCUM && loc_deg == '0 && loc_coef == LOC_BITS'(1)));

    // R8
    lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_coef[7:0] == 8'h01);

    // R8
    deg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_deg <= DEG_W'(2*CORR));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACCUM && !start) |=> ($stable(loc_coef) && $stable(loc_deg)));

endmodule

bind rs_kes_bm rs_kes_bm_chk #(.CORR(CORR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .syn_valid (syn_valid),
    .state     (state_q),
    .done      (done),
    .loc_deg   (loc_deg),
    .loc_coef  (loc_coef)
);

// File: tb/sim_rs_kes_bm.sv
`timescale 1ns/1ps
module sim_rs_kes_bm;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         syn_valid = 1'b0;
    logic [7:0]   syn_in = 8'h00;
    logic         done;
    logic [4:0]   loc_deg;
    logic [135:0] loc_coef;
    logic [63:0]  eval_coef;

    int n_chk = 0;
    int n_bad = 0;

    int alog[0:254];
    int dlog[0:255];
    logic [7:0] syn[1:16];
    logic [7:0] eloc[0:16];

    always #2.5 clk = ~clk;

    rs_kes_bm #(.CORR(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .syn_valid (syn_valid),
        .syn_in    (syn_in),
        .done      (done),
        .loc_deg   (loc_deg),
        .loc_coef  (loc_coef),
        .eval_coef (eval_coef)
    );

    // R9: log/antilog tables of the field, alpha = 0x02, poly 0x11D
    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        if (a == 8'h00 || b == 8'h00) return 8'h00;
        return 8'(alog[(dlog[a] + dlog[b]) % 255]);
    endfunction

    task automatic chk(input string req, input logic [135:0] act, input logic [135:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [135:0] exp_loc_flat();
        logic [135:0] f;
        f = '0;
        for (int i = 0; i <= 16; i++) f[i*8 +: 8] = eloc[i];
        return f;
    endfunction

    function automatic logic [135:0] exp_eval_flat();
        logic [135:0] f;
        f = '0;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] acc;
            acc = 8'h00;
            for (int i = 0; i <= k; i++) acc = acc ^ gm(eloc[i], syn[k+1-i]);
            f[k*8 +: 8] = acc;
        end
        return f;
    endfunction

    // R4 R9: syndromes S_j = XOR Y*alpha^(p*j), locator = prod (1 + alpha^p x)
    task automatic make_errors(input int v, input int trial);
        for (int j = 1; j <= 16; j++) syn[j] = 8'h00;
        for (int i = 0; i <= 16; i++) eloc[i] = 8'h00;
        eloc[0] = 8'h01;
        for (int e = 0; e < v; e++) begin
            int pos;
            logic [7:0] mag;
            logic [7:0] xl;
            pos = (trial * 37 + e * 31 + v * 11) % 255;
            mag = 8'(1 + ((trial * 13 + e * 29 + v) % 255));
            xl  = 8'(alog[pos]);
            for (int j = 1; j <= 16; j++) syn[j] = syn[j] ^ gm(mag, 8'(alog[(pos * j) % 255]));
            for (int i = 16; i >= 1; i--) eloc[i] = eloc[i] ^ gm(eloc[i-1], xl);
        end
    endtask

    // mode 0: dense stream; 1: gapped stream (R3); 2: aborted partial stream, restart collides with valid (R2)
    task automatic feed_word(input int mode, input int exp_deg);
        bit early;
        if (mode == 2) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            for (int j = 0; j < 5; j++) begin
                syn_valid = 1'b1; syn_in = 8'(j * 41 + 7);
                @(negedge clk);
            end
            syn_valid = 1'b0;
        end
        @(negedge clk);
        start = 1'b1;
        if (mode == 2) begin syn_valid = 1'b1; syn_in = 8'hA5; end
        @(negedge clk);
        start = 1'b0; syn_valid = 1'b0;
        early = 1'b0;
        for (int j = 1; j <= 16; j++) begin
            syn_valid = 1'b1; syn_in = syn[j];
            @(negedge clk);
            syn_valid = 1'b0;
            if (j < 16 && done) early = 1'b1;
            if (mode == 1 && j < 16 && (j % 3 == 1)) begin
                repeat (2) begin
                    @(negedge clk);
                    if (done) early = 1'b1;
                end
            end
        end
        chk($sformatf("R5 no early done mode=%0d", mode), 136'(early), 136'(0));
        chk("R5 done after last syndrome", 136'(done), 136'(1));
        @(negedge clk);
        chk("R5 done single cycle", 136'(done), 136'(0));
        chk($sformatf("R4 R3 degree mode=%0d", mode), 136'(loc_deg), 136'(exp_deg));
        chk($sformatf("R4 R9 locator mode=%0d", mode), loc_coef, exp_loc_flat());
        chk("R7 evaluator", 136'(eval_coef), exp_eval_flat());
    endtask

    initial begin
        int v;
        v = 1;
        for (int i = 0; i < 255; i++) begin
            alog[i] = v;
            dlog[v] = i;
            v = v << 1;
            if (v >= 256) v = v ^ 'h11D;
        end
        dlog[0] = 0;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset done", 136'(done), 136'(0));
        chk("R1 reset degree", 136'(loc_deg), 136'(0));
        chk("R1 reset locator", loc_coef, 136'(1));

        for (int ne = 0; ne <= 8; ne++) begin
            for (int trial = 0; trial < 20; trial++) begin
                make_errors(ne, trial);
                feed_word(trial % 3, ne);
            end
        end

        // R6: stray syndromes while idle are ignored
        begin
            logic [135:0] held_loc;
            logic [4:0]   held_deg;
            logic [63:0]  held_eval;
            bit saw_done;
            held_loc = loc_coef; held_deg = loc_deg; held_eval = eval_coef;
            saw_done = 1'b0;
            for (int j = 0; j < 6; j++) begin
                syn_valid = 1'b1; syn_in = 8'(j * 53 + 3);
                @(negedge clk);
                if (done) saw_done = 1'b1;
            end
            syn_valid = 1'b0;
            @(negedge clk);
            chk("R6 locator held", loc_coef, held_loc);
            chk("R6 degree held", 136'(loc_deg), 136'(held_deg));
            chk("R6 evaluator held", 136'(eval_coef), 136'(held_eval));
            chk("R6 no done while idle", 136'(saw_done), 136'(0));
        end

        // R8: only S16 nonzero -> degree 16, locator 1 + d*x^16
        for (int j = 1; j <= 16; j++) syn[j] = 8'h00;
        syn[16] = 8'h5A;
        for (int i = 0; i <= 16; i++) eloc[i] = 8'h00;
        eloc[0] = 8'h01; eloc[16] = 8'h5A;
        feed_word(0, 16);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule